// File: doc/BRIEF.md
# Shared Memory Gatekeeper with Hardware Semaphores

This block sits between one processor and a shared memory bus and carries out the processor's shared-memory accesses for it. The processor presents an address, a read/write flag and write data. The gatekeeper then does the rest. It raises a bus request and holds it until the arbiter grants the bus. It probes the addressed location, which returns the data word and a one-bit full/empty semaphore one cycle later. If the semaphore is in the required state, it commits the access. If it is not, it gives the bus back, waits a fixed backoff and tries again.

A read needs the location to be full. After a read, the gatekeeper writes the flag back to empty. A write needs the location to be empty. The write stores the data and sets the flag to full in a single commit. Each location has one producer and one consumer, so this gives ordered hand-over of words without any software semaphore handling.

Reads keep the processor stalled until the data is in hand and the flag has been cleared. Writes are posted into a one-entry buffer, so the processor continues at once. A further access that arrives while that write is still draining is stalled until the write commits.

Top module: `shmem_gatekeeper`

## Requirements
- R1: After reset, `cpu_wait`, `bus_req` and `bus_en` are all low while the processor makes no request.
- R2: A write presented while the gatekeeper is idle is accepted in that same cycle with `cpu_wait` low, and `bus_req` rises in the next cycle. Once it commits, the location holds the written data and its semaphore is 1 (full).
- R3: A read holds `cpu_wait` high until the data has been fetched and a semaphore clear (`bus_sem_we`=1, `bus_sem_set`=0) has been issued. The read completes in the one cycle where `cpu_wait` is low, and `cpu_rdata` then shows the location's data. With the bus granted at once and the flag full, `cpu_wait` is high for exactly 5 cycles.
- R4: `bus_req` stays asserted while the grant is pending. `bus_en` strobes occur only while both `bus_req` and `bus_gnt` are high. A grant delayed by N cycles lengthens an access by exactly N cycles.
- R5: Each attempt is a probe (`bus_en` with both write enables low), followed one cycle later by the check of `bus_full`. If the flag is wrong, the attempt writes neither data nor flag and `bus_req` falls. `bus_req` then stays low for exactly BACKOFF cycles (default 8) before the retry.
- R6: Any access presented while a posted write is still pending holds `cpu_wait` high until that write has committed. A write followed one cycle later by a read stalls the read for exactly 9 cycles.
- R7: A read of an empty location retries until the location becomes full, then returns the new data. A write to a full location retries and leaves the stored data and flag unchanged until a consumer empties the location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor shared-access request, held until accepted |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Shared-memory word address |
| cpu_wdata | input | DW | Write data |
| cpu_wait | output | 1 | Stall to the processor |
| cpu_rdata | output | DW | Read data, valid when a read completes |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_en | output | 1 | Memory access strobe |
| bus_we | output | 1 | Data write enable (with bus_en) |
| bus_sem_we | output | 1 | Semaphore write enable (with bus_en) |
| bus_sem_set | output | 1 | Semaphore value to write: 1 full, 0 empty |
| bus_addr | output | AW | Memory address |
| bus_wdata | output | DW | Memory write data |
| bus_rdata | input | DW | Data returned one cycle after a strobe |
| bus_full | input | 1 | Semaphore returned one cycle after a strobe |

## Verification
Two things can happen in the same cycle: a posted write is still draining through the bus, and the processor presents its next access. The bench provokes this by issuing a write and then, one cycle later, a read of the same location or a second write. The read is judged on three points. It must stay stalled for exactly the cycles the pending write needs plus its own full access. It must return the value just written. The location must end up empty. The second write must be held off for exactly the four remaining cycles of the first write, and then land with its own data.

// File: rtl/sgk_pkg.sv
package sgk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_PROBE,
        ST_CHECK,
        ST_COMMIT,
        ST_BACKOFF,
        ST_RDONE
    } sgk_state_e;
endpackage

// File: rtl/sgk_backoff.sv
module sgk_backoff #(
    parameter int BACKOFF = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = $clog2(BACKOFF + 1);

    typedef struct packed {
        logic          act;
        logic [CW-1:0] cnt;
    } bo_t;

    bo_t bo_d, bo_q;

    always_comb begin
        bo_d = bo_q;
        if (start) begin
            bo_d.act = 1'b1;
            bo_d.cnt = CW'(BACKOFF - 1);
        end else if (bo_q.act) begin
            if (bo_q.cnt == '0) bo_d.act = 1'b0;
            else                bo_d.cnt = bo_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bo_q <= '0;
        else        bo_q <= bo_d;
    end

    assign done = bo_q.act && (bo_q.cnt == '0);
endmodule

// File: rtl/sgk_ctrl.sv
module sgk_ctrl
    import sgk_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_wait,
    output logic [DW-1:0] cpu_rdata,
    output logic          bo_start,
    input  logic          bo_done,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          bus_en,
    output logic          bus_we,
    output logic          bus_sem_we,
    output logic          bus_sem_set,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_full
);
    typedef struct packed {
        sgk_state_e    st;
        logic          is_wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  flag_ok;

    always_comb begin
        c_d      = c_q;
        bo_start = 1'b0;
        flag_ok  = c_q.is_wr ? !bus_full : bus_full;
        case (c_q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    c_d.is_wr = cpu_we;
                    c_d.addr  = cpu_addr;
                    c_d.wdata = cpu_wdata;
                    c_d.st    = ST_REQ;
                end
            end
            ST_REQ:     if (bus_gnt) c_d.st = ST_PROBE;
            ST_PROBE:   c_d.st = ST_CHECK;
            ST_CHECK: begin
                if (!c_q.is_wr) c_d.rdata = bus_rdata;
                if (flag_ok) begin
                    c_d.st = ST_COMMIT;
                end else begin
                    c_d.st   = ST_BACKOFF;
                    bo_start = 1'b1;
                end
            end
            ST_COMMIT:  c_d.st = c_q.is_wr ? ST_IDLE : ST_RDONE;
            ST_BACKOFF: if (bo_done) c_d.st = ST_REQ;
            ST_RDONE:   c_d.st = ST_IDLE;
            default:    c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign bus_req     = (c_q.st == ST_REQ) || (c_q.st == ST_PROBE) ||
                         (c_q.st == ST_CHECK) || (c_q.st == ST_COMMIT);
    assign bus_en      = (c_q.st == ST_PROBE) || (c_q.st == ST_COMMIT);
    assign bus_we      = (c_q.st == ST_COMMIT) && c_q.is_wr;
    assign bus_sem_we  = (c_q.st == ST_COMMIT);
    assign bus_sem_set = (c_q.st == ST_COMMIT) && c_q.is_wr;
    assign bus_addr    = c_q.addr;
    assign bus_wdata   = c_q.wdata;

    assign cpu_wait  = cpu_req &&
                       !((c_q.st == ST_IDLE) && cpu_we) &&
                       !((c_q.st == ST_RDONE) && !cpu_we);
    assign cpu_rdata = c_q.rdata;
endmodule

// File: rtl/shmem_gatekeeper.sv
module shmem_gatekeeper #(
    parameter int AW      = 8,
    parameter int DW      = 16,
    parameter int BACKOFF = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_wait,
    output logic [DW-1:0] cpu_rdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          bus_en,
    output logic          bus_we,
    output logic          bus_sem_we,
    output logic          bus_sem_set,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_full
);
    logic bo_start, bo_done;

    sgk_backoff #(.BACKOFF(BACKOFF)) u_backoff (
        .clk   (clk),
        .rst_n (rst_n),
        .start (bo_start),
        .done  (bo_done)
    );

    sgk_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_req     (cpu_req),
        .cpu_we      (cpu_we),
        .cpu_addr    (cpu_addr),
        .cpu_wdata   (cpu_wdata),
        .cpu_wait    (cpu_wait),
        .cpu_rdata   (cpu_rdata),
        .bo_start    (bo_start),
        .bo_done     (bo_done),
        .bus_req     (bus_req),
        .bus_gnt     (bus_gnt),
        .bus_en      (bus_en),
        .bus_we      (bus_we),
        .bus_sem_we  (bus_sem_we),
        .bus_sem_set (bus_sem_set),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .bus_full    (bus_full)
    );
endmodule

// File: rtl/sgk_checker.sv
module sgk_checker (
    input logic clk,
    input logic rst_n,
    input logic cpu_req,
    input logic cpu_we,
    input logic cpu_wait,
    input logic bus_req,
    input logic bus_gnt,
    input logic bus_en,
    input logic bus_sem_we,
    input logic bus_sem_set,
    input logic bus_full
);
    assert_strobe_granted_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en |-> (bus_req && bus_gnt));

    assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);

    assert_write_posted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && !cpu_wait) |=> bus_req);

    assert_set_needs_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sem_we && bus_sem_set) |-> $past(!bus_full));

    assert_clear_needs_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sem_we && !bus_sem_set) |-> $past(bus_full));

    assert_commit_after_probe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sem_we |-> $past(bus_en && !bus_sem_we, 2));

    assert_read_after_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && !cpu_wait) |-> $past(bus_sem_we && !bus_sem_set));
endmodule

bind shmem_gatekeeper sgk_checker u_sgk_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_req     (cpu_req),
    .cpu_we      (cpu_we),
    .cpu_wait    (cpu_wait),
    .bus_req     (bus_req),
    .bus_gnt     (bus_gnt),
    .bus_en      (bus_en),
    .bus_sem_we  (bus_sem_we),
    .bus_sem_set (bus_sem_set),
    .bus_full    (bus_full)
);

// File: tb/tb_shmem_gatekeeper.sv
module tb_shmem_gatekeeper;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int BO = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_wait;
    logic [DW-1:0] cpu_rdata;
    logic          bus_req, bus_gnt, bus_en, bus_we, bus_sem_we, bus_sem_set;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;
    logic          bus_full;

    int checks = 0;
    int fails  = 0;
    int gnt_delay = 0;
    int sem_writes = 0;
    int ungranted = 0;

    logic [DW-1:0] mem  [DEPTH];
    logic          flag [DEPTH];
    logic          poke_en = 1'b0;
    logic [AW-1:0] poke_addr = '0;
    logic [DW-1:0] poke_data = '0;
    logic          poke_full = 1'b0;
    logic [7:0]    wcnt;

    always #4 clk = ~clk;

    shmem_gatekeeper #(.AW(AW), .DW(DW), .BACKOFF(BO)) dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wait(cpu_wait), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_en(bus_en), .bus_we(bus_we),
        .bus_sem_we(bus_sem_we), .bus_sem_set(bus_sem_set), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_full(bus_full)
    );

    // shared memory with one-cycle response, plus pokes from the other processor
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i]  <= '0;
                flag[i] <= 1'b0;
            end
            bus_rdata <= '0;
            bus_full  <= 1'b0;
        end else begin
            if (bus_en) begin
                if (bus_we)     mem[bus_addr]  <= bus_wdata;
                if (bus_sem_we) flag[bus_addr] <= bus_sem_set;
                bus_rdata <= mem[bus_addr];
                bus_full  <= flag[bus_addr];
            end
            if (poke_en) begin
                mem[poke_addr]  <= poke_data;
                flag[poke_addr] <= poke_full;
            end
        end
    end

    // arbiter: grant after gnt_delay cycles of request
    always @(posedge clk) begin
        if (!bus_req)        wcnt <= 8'd0;
        else if (wcnt != 8'hFF) wcnt <= wcnt + 8'd1;
    end
    assign bus_gnt = bus_req && (int'(wcnt) >= gnt_delay);

    always @(posedge clk) begin
        if (rst_n) begin
            if (bus_en && bus_sem_we) sem_writes++;
            if (bus_en && !bus_gnt)   ungranted++;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic poke(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic f);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = a; poke_data = d; poke_full = f;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic wait_sem(input int target);
        int n = 0;
        while (sem_writes < target && n < 400) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
    endtask

    task automatic post_write(input logic [AW-1:0] a, input logic [DW-1:0] d, output logic waited);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        #1 waited = cpu_wait;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] data, output int stalls);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        #1;
        stalls = 0;
        while (cpu_wait && stalls < 500) begin
            stalls++;
            @(negedge clk); #1;
        end
        data = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "cpu_wait after reset", int'(cpu_wait), 0);
        chk("R1", "bus_req after reset", int'(bus_req), 0);
        chk("R1", "bus_en after reset", int'(bus_en), 0);
    endtask

    task automatic t_posted_write();
        logic w;
        int base = sem_writes;
        post_write(4'd3, 16'hA5A5, w);
        chk("R2", "write accepted without stall", int'(w), 0);
        wait_sem(base + 1);
        chk("R2", "written data", int'(mem[3]), 'hA5A5);
        chk("R2", "flag set full", int'(flag[3]), 1);
        chk("R2", "bus released", int'(bus_req), 0);
    endtask

    task automatic t_read_full();
        logic [DW-1:0] d;
        int s;
        do_read(4'd3, d, s);
        chk("R3", "read data", int'(d), 'hA5A5);
        chk("R3", "read stall cycles", s, 5);
        chk("R3", "flag cleared by read", int'(flag[3]), 0);
    endtask

    task automatic t_read_retry();
        int base = sem_writes;
        int n = 0, rises = 0, lowcnt = 0, gap = -1;
        logic prev = 1'b0, seen_fall = 1'b0, poked = 1'b0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 4'd5;
        #1;
        while (cpu_wait && n < 600) begin
            if (poke_en) poke_en = 1'b0;
            if (bus_req && !prev) begin
                rises++;
                if (seen_fall && gap < 0) gap = lowcnt;
            end
            if (!bus_req && prev) seen_fall = 1'b1;
            if (!bus_req && seen_fall && gap < 0) lowcnt++;
            if (rises == 2 && !poked && !bus_req) begin
                chk("R5", "no semaphore write on failed attempts", sem_writes - base, 0);
                poke_en = 1'b1; poke_addr = 4'd5; poke_data = 16'h1234; poke_full = 1'b1;
                poked = 1'b1;
            end
            prev = bus_req;
            n++;
            @(negedge clk); #1;
        end
        poke_en = 1'b0;
        chk("R7", "read returns data after retry", int'(cpu_rdata), 'h1234);
        @(negedge clk);
        cpu_req = 1'b0;
        chk("R5", "bus_req low cycles between attempts", gap, BO);
        chk("R7", "read retried at least once", int'(rises >= 2), 1);
        chk("R7", "one semaphore clear for the read", sem_writes - base, 1);
        chk("R7", "flag emptied after retried read", int'(flag[5]), 0);
    endtask

    task automatic t_write_full();
        logic w;
        int base;
        poke(4'd7, 16'h1111, 1'b1);
        base = sem_writes;
        post_write(4'd7, 16'h2222, w);
        chk("R2", "write to full location still posted", int'(w), 0);
        repeat (30) @(negedge clk);
        chk("R7", "full location not overwritten", int'(mem[7]), 'h1111);
        chk("R7", "full flag untouched", int'(flag[7]), 1);
        chk("R7", "no semaphore write while full", sem_writes - base, 0);
        poke(4'd7, 16'h1111, 1'b0);
        wait_sem(base + 1);
        chk("R7", "write lands after consumer empties", int'(mem[7]), 'h2222);
        chk("R7", "flag full after landing", int'(flag[7]), 1);
    endtask

    task automatic t_back_to_back();
        int s = 0;
        int base;
        // write then read of the same location
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 4'd9; cpu_wdata = 16'hBEEF;
        #1 chk("R2", "first write not stalled", int'(cpu_wait), 0);
        @(negedge clk);
        cpu_we = 1'b0; cpu_addr = 4'd9;
        #1;
        while (cpu_wait && s < 500) begin
            s++;
            @(negedge clk); #1;
        end
        chk("R6", "read behind posted write returns it", int'(cpu_rdata), 'hBEEF);
        chk("R6", "read stall behind posted write", s, 9);
        @(negedge clk);
        cpu_req = 1'b0;
        chk("R6", "location empty after hand-over", int'(flag[9]), 0);
        // write then write
        base = sem_writes;
        s = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 4'd10; cpu_wdata = 16'h0A0A;
        @(negedge clk);
        cpu_addr = 4'd11; cpu_wdata = 16'h0B0B;
        #1 chk("R6", "second write stalled", int'(cpu_wait), 1);
        while (cpu_wait && s < 500) begin
            s++;
            @(negedge clk); #1;
        end
        chk("R6", "second write stall cycles", s, 4);
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        wait_sem(base + 2);
        chk("R6", "first write data", int'(mem[10]), 'h0A0A);
        chk("R6", "second write data", int'(mem[11]), 'h0B0B);
    endtask

    task automatic t_grant_delay();
        logic w;
        logic [DW-1:0] d;
        int s;
        int base = sem_writes;
        gnt_delay = 3;
        post_write(4'd12, 16'hC3C3, w);
        wait_sem(base + 1);
        do_read(4'd12, d, s);
        chk("R4", "read data with slow grant", int'(d), 'hC3C3);
        chk("R4", "stall grows by grant delay", s, 8);
        chk("R4", "no strobe without grant", ungranted, 0);
        gnt_delay = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_posted_write();
        t_read_full();
        t_read_retry();
        t_write_full();
        t_back_to_back();
        t_grant_delay();
        repeat (4) @(negedge clk);
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule